// File: doc/BRIEF.md
# Prescaled Reload Down-Counter Timer

This block is a 16-bit down-counting timer for a byte-wide peripheral bus. A prescaler divides the selected clock source by 4, 16, 64 or 256. Each prescaler tick lowers the count by one. When the count runs out, the block flags an end-of-count event. In continuous mode the timer reloads from a programmable 16-bit value and keeps running. In single-pass mode it stops and clears its own run bit.

Each end of count toggles a timer output. If the interrupt enable is set, the event also latches a flag that drives the interrupt line. The clock source is either the system clock or an external event pin. The event pin is synchronised with two flops and counts on its rising edges.

Software controls the block through seven byte registers. A control bit copies the reload value into the counter at once. Reading the low count byte freezes the matching high byte, so a 16-bit value read as two bytes stays coherent.

Top module: `reload_timer`

## Requirements
- R1: Each prescaler tick lowers the count by one. A tick at count 0000h wraps the count to FFFFh.
- R2: Continuous mode is set by CTRL (address 0) bit 1 = 1. In this mode the tick at count 1 is the end of count. It reloads the counter from the reload value, so the end of count repeats every reload × divider source ticks.
- R3: Single-pass mode is CTRL bit 1 = 0. At end of count the counter goes to 0 and the run bit (CTRL bit 0) clears, so no further end of count occurs.
- R4: Writing CTRL with bit 5 = 1 copies the reload value into the counter on that write. The reload value is set by RLD_LO (address 3) and RLD_HI (address 4). CTRL bit 5 always reads as 0.
- R5: CTRL bits 3:2 select the divider: 00 gives 4, 01 gives 16, 10 gives 64, 11 gives 256. The prescaler holds at zero while the run bit is 0. Divider 4 with reload 1 gives the shortest period, 4 source clocks.
- R6: Reading CNT_LO (address 5) returns the live low count byte and stores the high byte at that moment. A later read of CNT_HI (address 6) returns the stored byte.
- R7: The end-of-count flag is IID (address 2) bit 0. Reading IID returns the flag and clears it.
- R8: End of count sets the flag only while IEN (address 1) bit 0 is 1. The irq output equals the flag.
- R9: A reload value of 0000h gives 65536 ticks per period.
- R10: With CTRL bit 4 = 1, the source is the event input. The source then ticks once per synchronised rising edge of evt_in, and system clocks alone do not advance the timer.
- R11: tmr_out toggles once at each end of count.
- R12: After reset, CTRL, IEN, IID, the reload value and the counter read 0, and irq and tmr_out are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle (read side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| evt_in | input | 1 | External event input, asynchronous |
| irq | output | 1 | End-of-count interrupt request |
| tmr_out | output | 1 | Toggles at each end of count |

## Verification
Several behaviours are checked on every cycle by assertions:
- each tick decrements the count;
- reload happens on end of count and on the load bit;
- single-pass end of count clears the run bit;
- the flag never rises with the enable off;
- the output toggles at each end of count;
- the synchronised event produces one-cycle pulses.

Other behaviours only the bench scenarios can show:
- the exact period for each divider and reload value;
- the 65536-count meaning of a zero reload;
- coherent two-byte reads across a reload;
- clear-on-read of the flag;
- counting of external edges as opposed to system clocks.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_IEN    = 3'd1,
    A_IID    = 3'd2,
    A_RLD_LO = 3'd3,
    A_RLD_HI = 3'd4,
    A_CNT_LO = 3'd5,
    A_CNT_HI = 3'd6
  } reg_addr_e;

  localparam int unsigned B_RUN  = 0;
  localparam int unsigned B_CONT = 1;
  localparam int unsigned B_DIV0 = 2;
  localparam int unsigned B_SRC  = 4;
  localparam int unsigned B_LOAD = 5;
endpackage

// File: rtl/rt_event_sync.sv
module rt_event_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_in,
  output logic evt_pulse
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], evt_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // rising edge seen at the last synchroniser stage
  assign evt_pulse = sh_q[STAGES-1] & ~sh_q[STAGES];

  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |=> !evt_pulse);
endmodule

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned BASE_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src_tick,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int unsigned MAX_LOG2 = BASE_LOG2 + 2 * ((1 << SEL_W) - 1);
  localparam int unsigned PW = MAX_LOG2;

  logic [PW-1:0] pcnt_q, pcnt_d, limit;

  // divider 4^(sel+1): limit = 2^(BASE_LOG2 + 2*sel) - 1
  always_comb limit = PW'((PW'(1) << (BASE_LOG2 + 2 * int'(div_sel))) - 1);

  always_comb begin
    pcnt_d = pcnt_q;
    if (!run)          pcnt_d = '0;
    else if (src_tick) pcnt_d = (pcnt_q == limit) ? '0 : pcnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  assign tick = run & src_tick & (pcnt_q == limit);

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pcnt_q == '0);
endmodule

// File: rtl/rt_counter.sv
module rt_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load_now,
  input  logic         cont,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         eoc
);
  logic [W-1:0] cnt_q, cnt_d;

  assign eoc = tick & ~load_now & (cnt_q == W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load_now)  cnt_d = reload;
    else if (eoc)  cnt_d = cont ? reload : '0;
    else if (tick) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  assert_decrement_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_now && cnt_q != W'(1)) |=> cnt_q == $past(cnt_q) - W'(1));
  assert_cont_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && cont) |=> cnt_q == $past(reload));
  assert_load_now_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> cnt_q == $past(reload));
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              evt_in,
  output logic              irq,
  output logic              tmr_out
);
  localparam int unsigned CW = 2 * DATA_W;

  logic              run_q, run_d, cont_q, cont_d, src_q, src_d;
  logic [1:0]        div_q, div_d;
  logic              ien_q, ien_d, flag_q, flag_d, tout_q, tout_d;
  logic [CW-1:0]     rld_q, rld_d;
  logic [DATA_W-1:0] snap_q, snap_d;
  logic              wr_ctrl, load_now, evt_pulse, src_tick, tick, eoc;
  logic [CW-1:0]     count;

  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign load_now = wr_ctrl && reg_wdata[B_LOAD];

  rt_event_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .evt_pulse(evt_pulse));

  assign src_tick = src_q ? evt_pulse : 1'b1;

  rt_prescaler #(.SEL_W(2), .BASE_LOG2(2)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .src_tick(src_tick),
    .div_sel(div_q), .tick(tick));

  rt_counter #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_now(load_now),
    .cont(cont_q), .reload(rld_q), .count(count), .eoc(eoc));

  always_comb begin
    run_d  = run_q;
    cont_d = cont_q;
    div_d  = div_q;
    src_d  = src_q;
    ien_d  = ien_q;
    rld_d  = rld_q;
    snap_d = snap_q;
    tout_d = tout_q ^ eoc;
    if (eoc && !cont_q) run_d = 1'b0;
    if (wr_ctrl) begin
      run_d  = reg_wdata[B_RUN];
      cont_d = reg_wdata[B_CONT];
      div_d  = reg_wdata[B_DIV0 +: 2];
      src_d  = reg_wdata[B_SRC];
    end
    if (reg_wr && reg_addr == A_IEN)    ien_d = reg_wdata[0];
    if (reg_wr && reg_addr == A_RLD_LO) rld_d[DATA_W-1:0] = reg_wdata;
    if (reg_wr && reg_addr == A_RLD_HI) rld_d[CW-1:DATA_W] = reg_wdata;
    if (reg_rd && reg_addr == A_CNT_LO) snap_d = count[CW-1:DATA_W];
    // a new event wins over a clearing read in the same cycle
    flag_d = (eoc && ien_q) || (flag_q && !(reg_rd && reg_addr == A_IID));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cont_q <= 1'b0;
      div_q  <= '0;
      src_q  <= 1'b0;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
      tout_q <= 1'b0;
      rld_q  <= '0;
      snap_q <= '0;
    end else begin
      run_q  <= run_d;
      cont_q <= cont_d;
      div_q  <= div_d;
      src_q  <= src_d;
      ien_q  <= ien_d;
      flag_q <= flag_d;
      tout_q <= tout_d;
      rld_q  <= rld_d;
      snap_q <= snap_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:   reg_rdata = DATA_W'({src_q, div_q, cont_q, run_q});
      A_IEN:    reg_rdata = DATA_W'(ien_q);
      A_IID:    reg_rdata = DATA_W'(flag_q);
      A_RLD_LO: reg_rdata = rld_q[DATA_W-1:0];
      A_RLD_HI: reg_rdata = rld_q[CW-1:DATA_W];
      A_CNT_LO: reg_rdata = count[DATA_W-1:0];
      A_CNT_HI: reg_rdata = snap_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq     = flag_q;
  assign tmr_out = tout_q;

  assert_single_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !cont_q && !wr_ctrl) |=> !run_q);
  assert_flag_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(ien_q));
  assert_toggle_on_eoc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> tmr_out != $past(tmr_out));
  assert_ctrl_load_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTRL) |-> !reg_rdata[B_LOAD]);
endmodule

// File: tb/reload_timer_tb.sv
module reload_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       evt_in = 1'b0;
  logic       irq, tmr_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  reload_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_in(evt_in), .irq(irq), .tmr_out(tmr_out));

  // vectors: {div code, reload, expected period in clocks}
  localparam logic [39:0] VEC [6] = '{
    {8'd0, 16'd1, 16'd4},
    {8'd1, 16'd1, 16'd16},
    {8'd0, 16'd3, 16'd12},
    {8'd1, 16'd3, 16'd48},
    {8'd2, 16'd2, 16'd128},
    {8'd3, 16'd1, 16'd256}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse_evt(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt_in = 1'b1;
      repeat (2) @(negedge clk);
      evt_in = 1'b0;
      @(negedge clk);
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic period(output int n);
    logic prev;
    prev = tmr_out;
    n = 0;
    while (tmr_out == prev && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, lo, hi;
    logic t0;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    rd(3'd0, d); check("R12 ctrl", d, 0);
    rd(3'd1, d); check("R12 ien", d, 0);
    rd(3'd2, d); check("R12 iid", d, 0);
    rd(3'd4, d); check("R12 rld_hi", d, 0);
    rd(3'd5, lo); rd(3'd6, hi); check("R12 count", {hi, lo}, 0);
    check("R12 irq", irq, 0);
    check("R12 tmr_out", tmr_out, 0);

    // R2 R5 R11 period table, continuous, system clock
    foreach (VEC[i]) begin
      wr(3'd0, 8'h00);
      wr(3'd3, VEC[i][23:16]);
      wr(3'd4, VEC[i][31:24]);
      wr(3'd0, 8'h23 | (VEC[i][33:32] << 2));
      period(n); check("R5 first period", n, int'(VEC[i][15:0]));
      period(n); check("R2 R11 repeat period", n, int'(VEC[i][15:0]));
    end
    wr(3'd0, 8'h00);

    // R4 R6 coherent read, event source frozen
    wr(3'd3, 8'h34); wr(3'd4, 8'h12);
    wr(3'd0, 8'h33);
    rd(3'd0, d); check("R4 load bit reads 0", d[5], 0);
    rd(3'd5, lo); check("R4 loaded low", lo, 8'h34);
    wr(3'd3, 8'h78); wr(3'd4, 8'h56);
    wr(3'd0, 8'h33);
    rd(3'd6, hi); check("R6 snapshot high", hi, 8'h12);
    rd(3'd5, lo); rd(3'd6, hi); check("R4 R6 new count", {hi, lo}, 16'h5678);

    // R9 R1 R10 zero reload wraps, event source
    wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    wr(3'd0, 8'h33);
    t0 = tmr_out;
    repeat (20) @(negedge clk);
    rd(3'd5, lo); rd(3'd6, hi); check("R10 clocks alone do not count", {hi, lo}, 0);
    pulse_evt(4);
    rd(3'd5, lo); rd(3'd6, hi); check("R9 R1 wrap to FFFF", {hi, lo}, 16'hFFFF);
    check("R9 no end of count at zero", tmr_out, t0);

    // R10 events: divider 4, reload 2 -> end after 8 edges
    wr(3'd3, 8'h02); wr(3'd4, 8'h00);
    wr(3'd0, 8'h33);
    t0 = tmr_out;
    pulse_evt(7); check("R10 before 8th edge", tmr_out, t0);
    pulse_evt(1); check("R10 at 8th edge", tmr_out, !t0);
    wr(3'd0, 8'h00);

    // R7 R8 single pass, enable off then on
    rd(3'd2, d);
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h01);
    wr(3'd0, 8'h21);
    repeat (10) @(negedge clk);
    check("R8 no irq when disabled", irq, 0);
    rd(3'd2, d); check("R8 iid stays 0", d, 0);
    rd(3'd0, d); check("R3 run cleared", d[0], 0);
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h21);
    t0 = tmr_out;
    repeat (10) @(negedge clk);
    check("R8 irq when enabled", irq, 1);
    check("R11 single toggle", tmr_out, !t0);
    rd(3'd2, d); check("R7 iid set", d, 1);
    rd(3'd2, d); check("R7 cleared on read", d, 0);
    check("R7 irq dropped", irq, 0);
    t0 = tmr_out;
    repeat (40) @(negedge clk);
    check("R3 no further end of count", tmr_out, t0);
    rd(3'd5, lo); rd(3'd6, hi); check("R3 count at zero", {hi, lo}, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule